// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the data path of a small 8-bit processor core. A combinational arithmetic and logic unit works on two byte operands and a 5-bit operation code. It drives a result byte, a second result byte for multiply and divide, and the status byte that the operation would produce. An 8-bit status register sits next to the unit. It records the six arithmetic flags when the sequencer asks for it, and it holds the interrupt-enable and bit-store flags. Those two flags change only through their own set and clear strobes.

The second operand comes from either the register operand or the immediate operand, chosen by one select bit. Add-with-carry, subtract-with-carry and the two rotates use the carry bit of the status register as their extra input. The sequencer feeds back the previous result by writing the flags with `flag_we`. Register-file access, decode, program-counter control and interrupt handling sit outside this block.

Status byte layout, from bit 7 down to bit 0: I (interrupt enable), T (bit store), H (half carry), S (sign), V (overflow), N (negative), Z (zero), C (carry).

Operation codes on `op_sel`:

| Code | Operation | Code | Operation |
|---|---|---|---|
| 0 | add | 10 | exclusive-or |
| 1 | add with carry | 11 | one's complement |
| 2 | subtract | 12 | nibble swap |
| 3 | subtract with carry | 13 | shift left |
| 4 | increment | 14 | shift right |
| 5 | decrement | 15 | rotate left through C |
| 6 | negate | 16 | rotate right through C |
| 7 | compare | 17 | multiply |
| 8 | and | 18 | divide |
| 9 | or | 19 to 31 | no operation |

Top module: `alu8_status`

## Requirements
- R1: While reset is asserted and after it is released, `flags_q` reads 0x00 until the first flag update or set strobe.
- R2: Codes 0 and 1 give result = A + B (+ C for code 1) mod 256. C is the carry out of bit 7. H is the carry out of bit 3. V is set when both operands have the same sign and the result sign differs. Bits 5 down to 0 of `flags_next` are {H,S,V,N,Z,C}, with N = result bit 7 and Z = (result == 0).
- R3: Codes 2, 3 and 7 compute A - B (- C for code 3). C is set when the unsigned subtrahend plus the borrow-in is larger than A. H is the same test on the low nibbles. V is set when the operand signs differ and the difference sign differs from A. For compare (code 7), Z and N come from the difference, while `result` shows operand A unchanged.
- R4: In `flags_next` and in `flags_q`, bit 4 (S) always equals bit 3 (V) xor bit 2 (N).
- R5: Increment (4) and decrement (5) leave C and H unchanged. V is set exactly for increment of 0x7F and decrement of 0x80.
- R6: And, or, exclusive-or and complement (codes 8 to 11) clear V and leave C and H unchanged. Complement gives ~A.
- R7: Shift left puts bit 7 into C and bit 3 into H. Shift right puts bit 0 into C and clears N. Rotate left fills bit 0 with the old C. Rotate right fills bit 7 with the old C. For all four, V = N xor C.
- R8: Negate gives (256 - A) mod 256, with C = (A != 0), H = (A[3:0] != 0) and V = (A == 0x80). Nibble swap gives {A[3:0],A[7:4]} and leaves every flag unchanged.
- R9: Multiply drives the unsigned 16-bit product, with the low byte on `result` and the high byte on `result_hi`. C is product bit 15, Z is (product == 0), and H, V and N are unchanged.
- R10: Divide drives the quotient on `result` and the remainder on `result_hi`, and clears V. Z is (quotient == 0). With a zero divisor it drives 0xFF and the dividend, sets V and clears Z.
- R11: I (bit 7) and T (bit 6) change only through `set_i`/`clr_i` and `set_t`/`clr_t`, one cycle after the strobe. A set strobe wins over a clear strobe given in the same cycle.
- R12: `flags_q` bits 5 down to 0 take `flags_next` bits 5 down to 0 at a clock edge where `flag_we` is high, and hold otherwise.
- R13: Codes 19 to 31 drive zero on both result bytes and a `flags_next` equal to `flags_q`.
- R14: With `use_imm` high, the second operand is `imm` instead of `op_b`, for every two-operand operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation code |
| op_a | input | 8 | First operand (destination value) |
| op_b | input | 8 | Second operand from the register file |
| imm | input | 8 | Immediate second operand |
| use_imm | input | 1 | Selects `imm` as the second operand |
| flag_we | input | 1 | Loads H,S,V,N,Z,C into the status register |
| set_i | input | 1 | Sets the interrupt-enable flag |
| clr_i | input | 1 | Clears the interrupt-enable flag |
| set_t | input | 1 | Sets the bit-store flag |
| clr_t | input | 1 | Clears the bit-store flag |
| result | output | 8 | Result byte, or product low byte or quotient |
| result_hi | output | 8 | Product high byte or remainder, else zero |
| flags_next | output | 8 | Status byte the current operation produces |
| flags_q | output | 8 | Registered status byte |

## Verification
The only state in this block is the status register. A wrong stored bit shows up one cycle after the write that loaded it: directly on `flags_q`, and in the same cycle on `flags_next`. For unchanged-flag operations such as swap or the unused codes, the bad bit is copied straight through. For carry-consuming operations (add/subtract with carry, rotates), a wrong C also corrupts `result`. The bench therefore chains operations, so that a bad carry or a dropped write is caught on the very next operation, and it checks `flags_q` after every edge, including edges where `flag_we` is low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_INC  = 5'd4,
        OP_DEC  = 5'd5,
        OP_NEG  = 5'd6,
        OP_CMP  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_COM  = 5'd11,
        OP_SWAP = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_MUL  = 5'd17,
        OP_DIV  = 5'd18
    } alu_op_e;

    // packed order gives i at bit 7 down to c at bit 0
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [DW-1:0] hi;
        sreg_t         flags;
    } alu_out_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  sreg_t         sr_in,
    output alu_out_t      o
);
    logic [DW-1:0] ax, bx, r;
    logic          cin, is_sub, keep_ch;
    logic [DW:0]   wide;
    logic [NW:0]   half;
    logic          ovf;

    always_comb begin
        ax      = a;
        bx      = b;
        cin     = 1'b0;
        is_sub  = 1'b0;
        keep_ch = 1'b0;
        case (op)
            OP_ADC:         cin = sr_in.c;
            OP_SUB, OP_CMP: is_sub = 1'b1;
            OP_SBC: begin
                is_sub = 1'b1;
                cin    = sr_in.c;
            end
            OP_INC: begin
                bx      = {{(DW-1){1'b0}}, 1'b1};
                keep_ch = 1'b1;
            end
            OP_DEC: begin
                bx      = {{(DW-1){1'b0}}, 1'b1};
                is_sub  = 1'b1;
                keep_ch = 1'b1;
            end
            OP_NEG: begin
                ax     = '0;
                bx     = a;
                is_sub = 1'b1;
            end
            default: ;
        endcase

        if (is_sub) begin
            wide = {1'b0, ax} - {1'b0, bx} - {{DW{1'b0}}, cin};
            half = {1'b0, ax[NW-1:0]} - {1'b0, bx[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            wide = {1'b0, ax} + {1'b0, bx} + {{DW{1'b0}}, cin};
            half = {1'b0, ax[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cin};
        end
        r = wide[DW-1:0];

        if (is_sub)
            ovf = (ax[DW-1] != bx[DW-1]) && (r[DW-1] != ax[DW-1]);
        else
            ovf = (ax[DW-1] == bx[DW-1]) && (r[DW-1] != ax[DW-1]);

        o.flags   = sr_in;
        o.flags.n = r[DW-1];
        o.flags.z = (r == '0);
        o.flags.v = ovf;
        o.flags.s = r[DW-1] ^ ovf;
        if (!keep_ch) begin
            o.flags.c = wide[DW];
            o.flags.h = half[NW];
        end
        o.res = (op == OP_CMP) ? a : r;
        o.hi  = '0;
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  sreg_t         sr_in,
    output alu_out_t      o
);
    logic [DW-1:0] r;
    logic          v_new, c_new, h_new, flags_kept;

    always_comb begin
        r          = '0;
        v_new      = 1'b0;
        c_new      = sr_in.c;
        h_new      = sr_in.h;
        flags_kept = 1'b0;
        case (op)
            OP_AND: r = a & b;
            OP_OR:  r = a | b;
            OP_XOR: r = a ^ b;
            OP_COM: r = ~a;
            OP_SWAP: begin
                r          = {a[NW-1:0], a[DW-1:NW]};
                flags_kept = 1'b1;
            end
            OP_LSL, OP_ROL: begin
                r     = {a[DW-2:0], (op == OP_ROL) ? sr_in.c : 1'b0};
                c_new = a[DW-1];
                h_new = a[NW-1];
                v_new = r[DW-1] ^ a[DW-1];
            end
            OP_LSR, OP_ROR: begin
                r     = {(op == OP_ROR) ? sr_in.c : 1'b0, a[DW-1:1]};
                c_new = a[0];
                v_new = r[DW-1] ^ a[0];
            end
            default: ;
        endcase

        o.flags = sr_in;
        if (!flags_kept) begin
            o.flags.n = r[DW-1];
            o.flags.z = (r == '0);
            o.flags.v = v_new;
            o.flags.s = r[DW-1] ^ v_new;
            o.flags.c = c_new;
            o.flags.h = h_new;
        end
        o.res = r;
        o.hi  = '0;
    end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  sreg_t         sr_in,
    output alu_out_t      o
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] prod;
    logic [DW:0]   part;
    logic [DW-1:0] quo;
    logic          div_zero;

    always_comb begin
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};

        // restoring division, one trial subtraction per quotient bit
        part = '0;
        quo  = '0;
        for (int k = DW - 1; k >= 0; k--) begin
            part = {part[DW-1:0], a[k]};
            if (part >= {1'b0, b}) begin
                part   = part - {1'b0, b};
                quo[k] = 1'b1;
            end
        end
        div_zero = (b == '0);

        o.flags = sr_in;
        if (op == OP_DIV) begin
            o.res     = div_zero ? {DW{1'b1}} : quo;
            o.hi      = div_zero ? a : part[DW-1:0];
            o.flags.v = div_zero;
            o.flags.z = !div_zero && (quo == '0);
            o.flags.s = sr_in.n ^ div_zero;
        end else begin
            o.res     = prod[DW-1:0];
            o.hi      = prod[PW-1:DW];
            o.flags.c = prod[PW-1];
            o.flags.z = (prod == '0);
        end
    end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    input  logic [DW-1:0]  imm,
    input  logic           use_imm,
    input  logic           flag_we,
    input  logic           set_i,
    input  logic           clr_i,
    input  logic           set_t,
    input  logic           clr_t,
    output logic [DW-1:0]  result,
    output logic [DW-1:0]  result_hi,
    output logic [DW-1:0]  flags_next,
    output logic [DW-1:0]  flags_q
);
    typedef struct packed {
        sreg_t sr;
    } state_t;

    state_t        st_d, st_q;
    alu_op_e       op;
    logic [DW-1:0] b_sel;
    alu_out_t      arith_o, bit_o, md_o, sel_o;

    assign op    = alu_op_e'(op_sel);
    assign b_sel = use_imm ? imm : op_b;

    alu8_addsub u_addsub (.op(op), .a(op_a), .b(b_sel), .sr_in(st_q.sr), .o(arith_o));
    alu8_bitops u_bitops (.op(op), .a(op_a), .b(b_sel), .sr_in(st_q.sr), .o(bit_o));
    alu8_muldiv u_muldiv (.op(op), .a(op_a), .b(b_sel), .sr_in(st_q.sr), .o(md_o));

    always_comb begin
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC, OP_NEG, OP_CMP:
                sel_o = arith_o;
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_SWAP, OP_LSL, OP_LSR, OP_ROL, OP_ROR:
                sel_o = bit_o;
            OP_MUL, OP_DIV:
                sel_o = md_o;
            default: begin
                sel_o.res   = '0;
                sel_o.hi    = '0;
                sel_o.flags = st_q.sr;
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (flag_we) begin
            st_d.sr.h = sel_o.flags.h;
            st_d.sr.s = sel_o.flags.s;
            st_d.sr.v = sel_o.flags.v;
            st_d.sr.n = sel_o.flags.n;
            st_d.sr.z = sel_o.flags.z;
            st_d.sr.c = sel_o.flags.c;
        end
        if (set_i)      st_d.sr.i = 1'b1;
        else if (clr_i) st_d.sr.i = 1'b0;
        if (set_t)      st_d.sr.t = 1'b1;
        else if (clr_t) st_d.sr.t = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result     = sel_o.res;
    assign result_hi  = sel_o.hi;
    assign flags_next = sel_o.flags;
    assign flags_q    = st_q.sr;
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
    import alu8_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_sel,
    input logic [DW-1:0]  op_a,
    input logic [DW-1:0]  op_b,
    input logic [DW-1:0]  imm,
    input logic           use_imm,
    input logic           flag_we,
    input logic           set_i,
    input logic           clr_i,
    input logic           set_t,
    input logic           clr_t,
    input logic [DW-1:0]  result,
    input logic [DW-1:0]  result_hi,
    input logic [DW-1:0]  flags_next,
    input logic [DW-1:0]  flags_q
);
    logic [DW-1:0] opnd_b;
    assign opnd_b = use_imm ? imm : op_b;

    a_r4_sign_stored: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[4] == (flags_q[3] ^ flags_q[2]));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> flags_q[5:0] == $past(flags_q[5:0]));

    a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags_q[5:0] == $past(flags_next[5:0]));

    a_r11_i_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flags_q[7]);

    a_r11_i_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flags_q[7]));

    a_r11_t_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_t && !clr_t) |=> $stable(flags_q[6]));

    a_r11_it_pass: assert property (@(posedge clk) disable iff (!rst_n)
        flags_next[7:6] == flags_q[7:6]);

    a_r5_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_INC || op_sel == OP_DEC) |-> flags_next[0] == flags_q[0]);

    a_r6_logic_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= OP_AND && op_sel <= OP_COM) |->
            (flags_next[3] == 1'b0 && flags_next[0] == flags_q[0] && flags_next[5] == flags_q[5]));

    a_r9_mul_product: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_MUL) |-> {result_hi, result} == ({{DW{1'b0}}, op_a} * {{DW{1'b0}}, opnd_b}));

    a_r10_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_DIV && opnd_b == '0) |->
            (result == {DW{1'b1}} && result_hi == op_a && flags_next[3]));

    a_r13_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_DIV) |-> (result == '0 && result_hi == '0 && flags_next == flags_q));
endmodule

bind alu8_status alu8_status_chk u_chk (.*);

// File: tb/alu8_status_tb.sv
module alu8_status_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] op_a = '0, op_b = '0, imm = '0;
    logic       use_imm = 1'b0, flag_we = 1'b0;
    logic       set_i = 1'b0, clr_i = 1'b0, set_t = 1'b0, clr_t = 1'b0;
    logic [7:0] result, result_hi, flags_next, flags_q;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] exp_sr = '0;

    always #(CLK_P / 2) clk = ~clk;

    alu8_status u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
        .imm(imm), .use_imm(use_imm), .flag_we(flag_we),
        .set_i(set_i), .clr_i(clr_i), .set_t(set_t), .clr_t(clr_t),
        .result(result), .result_hi(result_hi),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model: {result, result_hi, flags}
    function automatic logic [23:0] ref_op(input int op, input int a, input int b, input logic [7:0] sr);
        int r, hi, d;
        bit h, v, n, z, cf, cin;
        h = sr[5]; v = sr[3]; n = sr[2]; z = sr[1]; cf = sr[0]; cin = sr[0];
        r = 0; hi = 0;
        if (op <= 1) begin
            d  = a + b + ((op == 1) ? int'(cin) : 0);
            r  = d % 256; cf = d > 255;
            h  = ((a % 16) + (b % 16) + ((op == 1) ? int'(cin) : 0)) > 15;
            v  = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
            n  = r >= 128; z = r == 0;
        end else if (op == 2 || op == 3 || op == 7 || op == 6) begin
            int x, y, bi;
            x = (op == 6) ? 0 : a; y = (op == 6) ? a : b;
            bi = (op == 3) ? int'(cin) : 0;
            d  = x - y - bi;
            r  = (d + 512) % 256; cf = d < 0;
            h  = ((x % 16) - (y % 16) - bi) < 0;
            v  = ((x >= 128) != (y >= 128)) && ((r >= 128) != (x >= 128));
            n  = r >= 128; z = r == 0;
            if (op == 7) r = a;
        end else if (op == 4) begin
            r = (a + 1) % 256; v = a == 127; n = r >= 128; z = r == 0;
        end else if (op == 5) begin
            r = (a + 255) % 256; v = a == 128; n = r >= 128; z = r == 0;
        end else if (op >= 8 && op <= 11) begin
            case (op)
                8:  r = a & b;
                9:  r = a | b;
                10: r = a ^ b;
                default: r = 255 - a;
            endcase
            v = 0; n = r >= 128; z = r == 0;
        end else if (op == 12) begin
            r = (a % 16) * 16 + a / 16;
        end else if (op == 13 || op == 15) begin
            r = (a * 2) % 256 + ((op == 15) ? int'(cin) : 0);
            cf = a >= 128; h = (a / 8) % 2 == 1;
            n = r >= 128; v = n ^ cf; z = r == 0;
        end else if (op == 14 || op == 16) begin
            r = a / 2 + ((op == 16 && cin) ? 128 : 0);
            cf = a % 2 == 1; n = r >= 128; v = n ^ cf; z = r == 0;
        end else if (op == 17) begin
            d = a * b; r = d % 256; hi = d / 256;
            cf = d >= 32768; z = d == 0;
        end else if (op == 18) begin
            if (b == 0) begin
                r = 255; hi = a; v = 1; z = 0;
            end else begin
                r = a / b; hi = a % b; v = 0; z = r == 0;
            end
        end
        return {r[7:0], hi[7:0], sr[7], sr[6], h, n ^ v, v, n, z, cf};
    endfunction

    task automatic run_op(input string tag, input int op, input int a, input int b,
                          input bit ui, input int im, input bit we,
                          input bit si, input bit ci, input bit st, input bit ct);
        logic [23:0] e;
        @(negedge clk);
        op_sel = op[4:0]; op_a = a[7:0]; op_b = b[7:0]; imm = im[7:0];
        use_imm = ui; flag_we = we; set_i = si; clr_i = ci; set_t = st; clr_t = ct;
        #1;
        e = ref_op(op, a, ui ? im : b, exp_sr);
        chk(tag, "result", result, e[23:16]);
        chk(tag, "result_hi", result_hi, e[15:8]);
        chk(tag, "flags_next", flags_next, e[7:0]);
        @(posedge clk);
        #1;
        if (we) exp_sr[5:0] = e[5:0];
        if (si) exp_sr[7] = 1'b1; else if (ci) exp_sr[7] = 1'b0;
        if (st) exp_sr[6] = 1'b1; else if (ct) exp_sr[6] = 1'b0;
        chk(tag, "flags_q", flags_q, exp_sr);
        flag_we = 0; set_i = 0; clr_i = 0; set_t = 0; clr_t = 0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R1", "flags_q in reset", flags_q, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 chk("R1", "flags_q after reset", flags_q, 8'h00);
        exp_sr = 8'h00;
    endtask

    task automatic t_add;
        run_op("R2", 0, 8'h0F, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R2", 0, 8'h7F, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R2", 0, 8'hFF, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R2", 1, 8'h10, 8'h20, 0, 0, 1, 0, 0, 0, 0);
        run_op("R2", 1, 8'h80, 8'h80, 0, 0, 1, 0, 0, 0, 0);
        run_op("R14", 0, 8'h05, 8'h99, 1, 8'h03, 1, 0, 0, 0, 0);
    endtask

    task automatic t_sub;
        run_op("R3", 2, 8'h10, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R3", 2, 8'h00, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R3", 3, 8'h05, 8'h05, 0, 0, 1, 0, 0, 0, 0);
        run_op("R3", 2, 8'h80, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R3", 7, 8'h30, 8'h30, 0, 0, 1, 0, 0, 0, 0);
        run_op("R3", 7, 8'h20, 8'h40, 0, 0, 1, 0, 0, 0, 0);
        run_op("R14", 2, 8'h50, 8'h00, 1, 8'h60, 1, 0, 0, 0, 0);
        run_op("R4", 2, 8'h7F, 8'hFF, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_incdec;
        run_op("R5", 2, 8'h00, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R5", 4, 8'h7F, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R5", 4, 8'hFF, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R5", 5, 8'h80, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R5", 5, 8'h01, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R5", 5, 8'h00, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_logic;
        run_op("R6", 0, 8'h88, 8'h88, 0, 0, 1, 0, 0, 0, 0);
        run_op("R6", 8, 8'hF0, 8'h3C, 0, 0, 1, 0, 0, 0, 0);
        run_op("R6", 9, 8'h00, 8'h00, 0, 0, 1, 0, 0, 0, 0);
        run_op("R6", 10, 8'hAA, 8'h00, 1, 8'h55, 1, 0, 0, 0, 0);
        run_op("R6", 11, 8'h0F, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_shift;
        run_op("R7", 13, 8'h88, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R7", 15, 8'h41, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R7", 14, 8'h01, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R7", 16, 8'h02, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R7", 16, 8'h03, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R7", 15, 8'h80, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_unary;
        run_op("R8", 6, 8'h00, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R8", 6, 8'h80, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R8", 6, 8'h01, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R8", 12, 8'hA5, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_mul;
        run_op("R9", 17, 8'hFF, 8'hFF, 0, 0, 1, 0, 0, 0, 0);
        run_op("R9", 17, 8'h00, 8'h37, 0, 0, 1, 0, 0, 0, 0);
        run_op("R9", 17, 8'h0C, 8'h00, 1, 8'h0D, 1, 0, 0, 0, 0);
    endtask

    task automatic t_div;
        run_op("R10", 18, 200, 7, 0, 0, 1, 0, 0, 0, 0);
        run_op("R10", 18, 5, 0, 0, 0, 1, 0, 0, 0, 0);
        run_op("R10", 18, 3, 10, 0, 0, 1, 0, 0, 0, 0);
        run_op("R10", 18, 255, 1, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_it;
        run_op("R11", 0, 8'hFF, 8'h01, 0, 0, 1, 1, 0, 0, 0);
        run_op("R11", 0, 8'h01, 8'h01, 0, 0, 1, 0, 0, 1, 0);
        run_op("R11", 4, 8'h10, 0, 0, 0, 1, 0, 1, 0, 0);
        run_op("R11", 12, 8'h12, 0, 0, 0, 0, 1, 1, 0, 1);
        run_op("R11", 2, 8'h01, 8'h02, 0, 0, 1, 0, 0, 1, 1);
        run_op("R11", 9, 8'h00, 8'h00, 0, 0, 1, 0, 1, 0, 1);
    endtask

    task automatic t_hold;
        run_op("R12", 0, 8'hFF, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        run_op("R12", 2, 8'h00, 8'h01, 0, 0, 0, 0, 0, 0, 0);
        run_op("R12", 8, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        run_op("R12", 1, 8'h01, 8'h01, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_unused;
        run_op("R4", 2, 8'h80, 8'h01, 0, 0, 1, 1, 0, 0, 0);
        run_op("R13", 19, 8'h5A, 8'h33, 0, 0, 1, 0, 0, 0, 0);
        run_op("R13", 31, 8'hFF, 8'hFF, 1, 8'h01, 1, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_incdec();
        t_logic();
        t_shift();
        t_unary();
        t_mul();
        t_div();
        t_it();
        t_hold();
        t_unused();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule